// File: doc/BRIEF.md
# Program-Order Trace Stream Merger

This block takes several parallel streams of trace records, one per issue lane of a wide core, and folds them into a single stream in program order. Every record carries a serial number next to an opaque payload word. A lane delivers its own records with rising serial numbers. Each serial number is issued exactly once, to exactly one lane. Because of this, the merged stream can be rebuilt without comparing the lanes against each other.

The merger holds a running "next serial" register. In each cycle it looks at the head record of every lane and picks the single head whose serial equals that register. It forwards that record downstream and, when the downstream side accepts it, moves the register on by one. Each input and the output use valid/ready handshakes. The path from heads to output is combinational, so a matching head can leave in the same cycle it is offered. A parameter chooses how the winning lane is multiplexed onto the output: either an AND-OR reduction or a priority chain.

Top module: `trace_merge_seq`

## Requirements
- R1: After reset the next-serial register is 0. A head carrying any other serial is not forwarded, and the first record sent out has serial 0.
- R2: `out_valid` is high exactly when some lane has `in_valid` high and a head serial equal to the next-serial value. In that cycle `out_data` equals the payload of that head.
- R3: At most one bit of `in_ready` is high. It is the bit of the matching lane, and only while `out_ready` is high. Two valid heads with the same serial are illegal input and are flagged by an assertion.
- R4: When `out_valid` is high, `out_serial` equals the next-serial value. That value steps by one after each accepted transfer (`out_valid` and `out_ready` both high at a rising edge). It wraps modulo 2^SER_W, so the serials that leave the block are consecutive.
- R5: When no valid head matches, `out_valid` is low and every bit of `in_ready` is low.
- R6: While `out_ready` is low, every bit of `in_ready` is low and the next-serial value does not change. The matching head is forwarded once `out_ready` rises.
- R7: Lane i's fields sit at bits [i*SER_W +: SER_W] of `in_serial` and bits [i*DATA_W +: DATA_W] of `in_data`. Bit i of `in_valid` and bit i of `in_ready` belong to lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Head valid, one bit per lane |
| in_ready | output | LANES | Head consumed, one bit per lane |
| in_serial | input | LANES*SER_W | Head serial numbers, packed per lane |
| in_data | input | LANES*DATA_W | Head payloads, packed per lane |
| out_valid | output | 1 | Merged record valid |
| out_ready | input | 1 | Downstream accepts merged record |
| out_serial | output | SER_W | Serial of merged record |
| out_data | output | DATA_W | Payload of merged record |

## Verification
`out_valid`, `out_serial`, `out_data` and `in_ready` follow the lane heads and `out_ready` in the same cycle, with no register in between. The next-serial value changes only at the rising edge that ends an accepted transfer, so its effect appears in the following cycle. The bench therefore drives the inputs just after the falling edge and samples every output two time units later, before the next rising edge. It advances its queue-based reference model only after that rising edge. With 200 records spread randomly over four lanes and a 6-bit serial, the serial wraps more than once, and random lane stalls and output stalls produce cycles with no match and cycles that are held.

// File: rtl/trm_pkg.sv
package trm_pkg;
   typedef enum logic [0:0] {
      SEL_ANDOR    = 1'b0,
      SEL_PRIORITY = 1'b1
   } sel_kind_e;
endpackage

// File: rtl/trm_head_match.sv
module trm_head_match #(
   parameter int SER_W = 6
) (
   input  logic             head_valid,
   input  logic [SER_W-1:0] head_serial,
   input  logic [SER_W-1:0] want_serial,
   output logic             hit
);
   always_comb hit = head_valid && (head_serial == want_serial);
endmodule

// File: rtl/trm_expect_ctr.sv
module trm_expect_ctr #(
   parameter int SER_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [SER_W-1:0] want_serial
);
   localparam logic [SER_W-1:0] ONE = SER_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) want_serial <= '0;
      else if (step) want_serial <= want_serial + ONE;
   end

   // R6: with no step the counter keeps its value
   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(want_serial));
endmodule

// File: rtl/trm_select.sv
module trm_select #(
   parameter int                 LANES = 4,
   parameter int                 W     = 22,
   parameter trm_pkg::sel_kind_e KIND  = trm_pkg::SEL_ANDOR
) (
   input  logic [LANES-1:0]   hit,
   input  logic [LANES*W-1:0] words,
   output logic               any,
   output logic [W-1:0]       sel_word
);
   always_comb any = |hit;

   generate
      if (KIND == trm_pkg::SEL_ANDOR) begin : g_andor
         logic [W-1:0] masked [LANES];
         for (genvar i = 0; i < LANES; i++) begin : g_mask
            assign masked[i] = words[i*W +: W] & {W{hit[i]}};
         end
         always_comb begin
            sel_word = '0;
            for (int i = 0; i < LANES; i++) sel_word = sel_word | masked[i];
         end
      end else begin : g_prio
         always_comb begin
            sel_word = '0;
            for (int i = LANES-1; i >= 0; i--) begin
               if (hit[i]) sel_word = words[i*W +: W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/trace_merge_seq.sv
module trace_merge_seq #(
   parameter int                 LANES  = 4,
   parameter int                 SER_W  = 6,
   parameter int                 DATA_W = 16,
   parameter trm_pkg::sel_kind_e SEL    = trm_pkg::SEL_ANDOR
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        in_valid,
   output logic [LANES-1:0]        in_ready,
   input  logic [LANES*SER_W-1:0]  in_serial,
   input  logic [LANES*DATA_W-1:0] in_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [SER_W-1:0]        out_serial,
   output logic [DATA_W-1:0]       out_data
);
   localparam int REC_W = SER_W + DATA_W;

   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (SER_W >= 2) else $error("SER_W must be at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   logic [SER_W-1:0]        want;
   logic [LANES-1:0]        hit;
   logic [LANES*REC_W-1:0]  recs;
   logic [REC_W-1:0]        win;
   logic                    xfer;

   trm_expect_ctr #(.SER_W(SER_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(xfer), .want_serial(want)
   );

   // R7: lane i occupies slice i of each packed input bus
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      trm_head_match #(.SER_W(SER_W)) u_match (
         .head_valid (in_valid[i]),
         .head_serial(in_serial[i*SER_W +: SER_W]),
         .want_serial(want),
         .hit        (hit[i])
      );
      assign recs[i*REC_W +: REC_W] = {in_serial[i*SER_W +: SER_W], in_data[i*DATA_W +: DATA_W]};
      assign in_ready[i] = hit[i] & out_ready;
   end

   trm_select #(.LANES(LANES), .W(REC_W), .KIND(SEL)) u_sel (
      .hit(hit), .words(recs), .any(out_valid), .sel_word(win)
   );

   assign out_serial = win[REC_W-1 -: SER_W];
   assign out_data   = win[DATA_W-1:0];
   assign xfer       = out_valid & out_ready;

   assert_unique_heads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
   assert_ready_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));
   assert_idle_no_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (in_ready == '0));
   assert_stall_no_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> (in_ready == '0));
   assert_out_serial_is_want_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_serial == want));
   assert_consecutive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid || out_serial == SER_W'($past(out_serial) + 1'b1)));
endmodule

// File: tb/trace_merge_seq_bench.sv
module trace_merge_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 4;
   localparam int SER_W  = 6;
   localparam int DATA_W = 16;
   localparam int TOTAL  = 200;
   localparam int LIMIT  = 20000;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [LANES-1:0]        in_valid = '0;
   logic [LANES-1:0]        in_ready;
   logic [LANES*SER_W-1:0]  in_serial = '0;
   logic [LANES*DATA_W-1:0] in_data = '0;
   logic                    out_valid;
   logic                    out_ready = 1'b0;
   logic [SER_W-1:0]        out_serial;
   logic [DATA_W-1:0]       out_data;

   int checks = 0;
   int errors = 0;
   int q [LANES][$];

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_merge_seq #(.LANES(LANES), .SER_W(SER_W), .DATA_W(DATA_W)) u_trace_merge_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_serial(in_serial), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_serial(out_serial), .out_data(out_data)
   );

   function automatic logic [DATA_W-1:0] pay(int s);
      return DATA_W'((s * 40503) ^ 16'h5a3c);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   initial begin
      int exp_s = 0;
      int done = 0;
      int cycles = 0;
      for (int s = 0; s < TOTAL; s++) q[$urandom % LANES].push_back(s);

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: a head with serial 1 must not leave first
      in_valid = 4'b0001;
      in_serial[0 +: SER_W] = SER_W'(1);
      in_data[0 +: DATA_W] = pay(1);
      out_ready = 1'b1;
      #2;
      chk(out_valid == 1'b0, "R1 out_valid with serial 1 head", out_valid, 0);
      chk(in_ready == '0, "R1 in_ready with serial 1 head", in_ready, 0);
      @(negedge clk);
      // R6: matching head offered while out_ready low
      in_valid = 4'b0011;
      in_serial[SER_W +: SER_W] = '0;
      in_data[DATA_W +: DATA_W] = pay(0);
      out_ready = 1'b0;
      #2;
      chk(out_valid == 1'b1, "R1 out_valid with serial 0 head", out_valid, 1);
      chk(out_serial == '0, "R1 first serial", out_serial, 0);
      chk(in_ready == '0, "R6 in_ready while out_ready low", in_ready, 0);

      while (done < TOTAL && cycles < LIMIT) begin
         int hit_lane;
         logic [LANES-1:0] exp_rdy;
         @(negedge clk);
         cycles++;
         hit_lane = -1;
         for (int l = 0; l < LANES; l++) begin
            bit v;
            v = (q[l].size() > 0) && (($urandom % 4) != 0);
            in_valid[l] = v;
            if (q[l].size() > 0) begin
               in_serial[l*SER_W +: SER_W] = SER_W'(q[l][0]);
               in_data[l*DATA_W +: DATA_W] = pay(q[l][0]);
               if (v && q[l][0] == exp_s) hit_lane = l;
            end else begin
               in_serial[l*SER_W +: SER_W] = SER_W'($urandom);
               in_data[l*DATA_W +: DATA_W] = DATA_W'($urandom);
            end
         end
         out_ready = (($urandom % 5) != 0);
         exp_rdy = (hit_lane >= 0 && out_ready) ? LANES'(1 << hit_lane) : '0;
         #2;
         chk(out_valid == (hit_lane >= 0), (hit_lane >= 0) ? "R2 out_valid" : "R5 out_valid",
             out_valid, (hit_lane >= 0));
         if (hit_lane >= 0) begin
            chk(out_serial == SER_W'(exp_s), "R4 out_serial", out_serial, exp_s % (1 << SER_W));
            chk(out_data == pay(exp_s), "R2/R7 out_data", out_data, pay(exp_s));
         end
         chk(in_ready == exp_rdy,
             !out_ready ? "R6 in_ready" : (hit_lane >= 0 ? "R3 in_ready" : "R5 in_ready"),
             in_ready, exp_rdy);
         @(posedge clk);
         if (hit_lane >= 0 && out_ready) begin
            void'(q[hit_lane].pop_front());
            exp_s++;
            done++;
         end
      end

      if (done < TOTAL) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual=%0d expected=%0d records", done, TOTAL);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule